// File: doc/BRIEF.md
# Dual-Organisation LUT RAM Element

This block is one 64-bit lookup-table storage cell used as a small RAM. A static configuration bit chooses how the 64 bits are seen: as 64 one-bit entries, or as 32 two-bit entries. Writes are synchronous to the rising clock edge and gated by a write enable. Reads are combinational, so a read always shows the current contents.

The element has an 8-bit write address, a 6-bit read address, a 2-bit data input and two 1-bit outputs, `outHi` and `outLo`. A second configuration bit selects single-port use, where the read path follows the write address and the read address input is ignored. It can also select dual-port use, where the read address is independent of the write address. Write address bits 7:6 exist only so that deeper memories can be built from several elements. A standalone element ignores them.

In the two-bit organisation, entry k keeps its lower bit in cell k and its upper bit in cell k+32. As a result, the two views share storage in a defined way. An active-low `rstN`, held low only at start-up, loads the array from the `INIT_VALUE` parameter (zero by default) and blocks writes. No other event clears the array.

Top module: `lutram_cell`

## Requirements
- R1: While `rstN` is low at a rising edge, the array loads `INIT_VALUE` (default all zero) and no write takes place; after reset every read returns 0 on both outputs.
- R2: With `cfgWide`=0, a rising edge with `wrEn`=1 stores `dataIn[0]` in cell `wrAddr[5:0]`; `dataIn[1]` is not stored anywhere.
- R3: With `cfgWide`=0, `outHi` equals the cell selected by the 6-bit read index and `outLo` is 0.
- R4: With `cfgWide`=1, a rising edge with `wrEn`=1 stores `dataIn[1:0]` in entry `wrAddr[4:0]`; `wrAddr[5]` has no effect.
- R5: With `cfgWide`=1, `outHi` is the upper bit and `outLo` the lower bit of the entry selected by read index bits 4:0; read index bit 5 has no effect.
- R6: With `cfgSinglePort`=1, the read index is `wrAddr[5:0]` and `rdAddr` has no effect on the outputs.
- R7: With `cfgSinglePort`=0, the read index is `rdAddr`, independent of `wrAddr`.
- R8: Reads are combinational: after the edge that writes an address, the outputs show the new data within the same cycle while that address stays selected.
- R9: `wrAddr[7:6]` never affects which cell is written or read.
- R10: A rising edge with `wrEn`=0 leaves every cell unchanged, whatever the data and addresses are.
- R11: The views share storage: the lower bit of two-bit entry k is one-bit cell k, and its upper bit is one-bit cell k+32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rstN | input | 1 | Active-low start-up load of `INIT_VALUE`; blocks writes |
| cfgWide | input | 1 | Organisation: 0 = 64x1, 1 = 32x2 (static) |
| cfgSinglePort | input | 1 | 1 = read index follows write address, 0 = separate read address (static) |
| wrAddr | input | 8 | Write address; bits 7:6 unused by one element |
| rdAddr | input | 6 | Read address used in dual-port configuration |
| dataIn | input | 2 | Write data; bit 1 used only in 32x2 |
| wrEn | input | 1 | Write enable |
| outHi | output | 1 | Addressed bit (64x1) or upper bit of entry (32x2) |
| outLo | output | 1 | Lower bit of entry (32x2), 0 in 64x1 |

## Verification
The hardest condition to reach is the aliasing between the two organisations. Cell k+32 is reachable as a one-bit address but in 32x2 is only the upper half of entry k. A bug that misplaces the upper half therefore stays hidden as long as each view is read back only by itself. The bench fills the whole array in one organisation, flips `cfgWide` and sweeps every address in the other, in both directions, so that every cell is compared through both views. It also drives decoy values on the ignored inputs (`rdAddr` in single-port, `wrAddr[7:6]`, `wrAddr[5]` and `dataIn[1]` where unused) during every write and read, and checks the outputs right after each write edge.

// File: rtl/lutram_pkg.sv
`timescale 1ns/1ps
package lutram_pkg;

  // Cell index width: 2**CELL_AW storage bits per element.
  localparam int CELL_AW  = 6;
  localparam int CELLS    = 1 << CELL_AW;
  localparam int HALF     = CELLS / 2;
  localparam int ENTRY_AW = CELL_AW - 1;
  // Write address is wider than the cell index so elements can be stacked.
  localparam int WADDR_W  = CELL_AW + 2;
  localparam int DATA_W   = 2;

  typedef enum logic {
    ORG_DEEP = 1'b0,   // 64 x 1
    ORG_WIDE = 1'b1    // 32 x 2
  } org_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic               wide;
    logic               wrLo;
    logic               wrHi;
    logic [CELL_AW-1:0] wrCellLo;
    logic [CELL_AW-1:0] wrCellHi;
    logic [CELL_AW-1:0] rdCellLo;
    logic [CELL_AW-1:0] rdCellHi;
  } strobes_t;

endpackage

// File: rtl/lutram_ctrl.sv
`timescale 1ns/1ps
module lutram_ctrl
  import lutram_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWide,
  input  logic               cfgSinglePort,
  input  logic [CELL_AW-1:0] wrAddr,
  input  logic [CELL_AW-1:0] rdAddr,
  input  logic               wrEn,
  output strobes_t           strobes
);

  org_e               org;
  logic [CELL_AW-1:0] rdSrc;
  logic               wrGo;

  assign org   = org_e'(cfgWide);
  assign rdSrc = cfgSinglePort ? wrAddr : rdAddr;
  assign wrGo  = wrEn & rstN;

  always_comb begin
    strobes      = '0;
    strobes.wide = (org == ORG_WIDE);
    unique case (org)
      ORG_WIDE: begin
        // Entry k: lower bit in lower half, upper bit in upper half.
        strobes.wrLo     = wrGo;
        strobes.wrHi     = wrGo;
        strobes.wrCellLo = {1'b0, wrAddr[ENTRY_AW-1:0]};
        strobes.wrCellHi = {1'b1, wrAddr[ENTRY_AW-1:0]};
        strobes.rdCellLo = {1'b0, rdSrc[ENTRY_AW-1:0]};
        strobes.rdCellHi = {1'b1, rdSrc[ENTRY_AW-1:0]};
      end
      default: begin
        strobes.wrLo     = wrGo;
        strobes.wrHi     = 1'b0;
        strobes.wrCellLo = wrAddr;
        strobes.wrCellHi = wrAddr;
        strobes.rdCellLo = rdSrc;
        strobes.rdCellHi = rdSrc;
      end
    endcase
  end

  // R10: no write strobe without the enable
  p_no_strobe_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (!strobes.wrLo && !strobes.wrHi));

  // R4: upper-half write only in the wide organisation, paired with the lower one
  p_hi_paired_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHi |-> (strobes.wrLo && cfgWide &&
                      strobes.wrCellHi[CELL_AW-1] && !strobes.wrCellLo[CELL_AW-1]));

  // R6: single-port read path follows the write address
  p_single_port_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSinglePort && !cfgWide) |-> (strobes.rdCellLo == wrAddr));

endmodule

// File: rtl/lutram_datapath.sv
`timescale 1ns/1ps
module lutram_datapath
  import lutram_pkg::*;
#(
  parameter logic [CELLS-1:0] INIT_VALUE = '0
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic              outHi,
  output logic              outLo
);

  logic [CELLS-1:0] cells;
  logic             rdBitLo;
  logic             rdBitHi;

  // Synchronous write; start-up load while rstN is low.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cells <= INIT_VALUE;
    end else begin
      if (strobes.wrLo) cells[strobes.wrCellLo] <= dataIn[0];
      if (strobes.wrHi) cells[strobes.wrCellHi] <= dataIn[1];
    end
  end

  // Combinational read.
  assign rdBitLo = cells[strobes.rdCellLo];
  assign rdBitHi = cells[strobes.rdCellHi];

  generate
    if (CELLS > 1) begin : g_outMux
      always_comb begin
        if (strobes.wide) begin
          outHi = rdBitHi;
          outLo = rdBitLo;
        end else begin
          outHi = rdBitLo;
          outLo = 1'b0;
        end
      end
    end
  endgenerate

  // R1: first cycle out of reset sees the start-up contents
  p_reset_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cells == INIT_VALUE));

  // R2: the write lands at the strobed cell
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.wrLo)) |-> (cells[$past(strobes.wrCellLo)] == $past(dataIn[0])));

  // R10: no strobe, no change anywhere in the array
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobes.wrLo || strobes.wrHi)) |-> $stable(cells));

  // R3: narrow organisation keeps the second output low
  p_narrow_lo_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wide |-> (outLo == 1'b0));

endmodule

// File: rtl/lutram_cell.sv
`timescale 1ns/1ps
module lutram_cell
  import lutram_pkg::*;
#(
  parameter logic [CELLS-1:0] INIT_VALUE = '0
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWide,
  input  logic               cfgSinglePort,
  input  logic [WADDR_W-1:0] wrAddr,
  input  logic [CELL_AW-1:0] rdAddr,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               wrEn,
  output logic               outHi,
  output logic               outLo
);

  strobes_t strobes;

  // Stacking bits are not decoded by a single element.
  logic unusedStackBits;
  assign unusedStackBits = ^wrAddr[WADDR_W-1:CELL_AW];

  lutram_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWide      (cfgWide),
    .cfgSinglePort(cfgSinglePort),
    .wrAddr       (wrAddr[CELL_AW-1:0]),
    .rdAddr       (rdAddr),
    .wrEn         (wrEn),
    .strobes      (strobes)
  );

  lutram_datapath #(
    .INIT_VALUE(INIT_VALUE)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dataIn (dataIn),
    .outHi  (outHi),
    .outLo  (outLo)
  );

endmodule

// File: tb/lutram_cell_test.sv
`timescale 1ns/1ps
module lutram_cell_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWide = 1'b0;
  logic       cfgSinglePort = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [5:0] rdAddr = '0;
  logic [1:0] dataIn = '0;
  logic       wrEn = 1'b0;
  logic       outHi;
  logic       outLo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;
  logic [63:0] model = '0;

  always #2.5 clk = ~clk;

  lutram_cell uut (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .cfgSinglePort(cfgSinglePort),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dataIn(dataIn), .wrEn(wrEn),
    .outHi(outHi), .outLo(outLo)
  );

  task automatic check(input string tag, input logic expHi, input logic expLo);
    checks++;
    if (outHi !== expHi || outLo !== expLo) begin
      errors++;
      $display("FAIL %s: wide=%0b sp=%0b wa=%0h ra=%0h got hi/lo=%0b%0b expected %0b%0b",
               tag, cfgWide, cfgSinglePort, wrAddr, rdAddr, outHi, outLo, expHi, expLo);
    end
  endtask

  // Expected outputs from the requirements (R3, R5, R6, R7, R11).
  task automatic expectFor(output logic eh, output logic el);
    logic [5:0] idx;
    idx = cfgSinglePort ? wrAddr[5:0] : rdAddr;
    if (cfgWide) begin
      eh = model[{1'b1, idx[4:0]}];
      el = model[{1'b0, idx[4:0]}];
    end else begin
      eh = model[idx];
      el = 1'b0;
    end
  endtask

  task automatic readAt(input string tag, input logic [7:0] wa, input logic [5:0] ra);
    logic eh, el;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = wa; rdAddr = ra;
    #1;
    expectFor(eh, el);
    check(tag, eh, el);
  endtask

  task automatic writeAt(input logic [7:0] wa, input logic [1:0] d, input logic [5:0] ra);
    @(negedge clk);
    wrAddr = wa; dataIn = d; rdAddr = ra; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (cfgWide) begin
      model[{1'b0, wa[4:0]}] = d[0];
      model[{1'b1, wa[4:0]}] = d[1];
    end else begin
      model[wa[5:0]] = d[0];
    end
  endtask

  task automatic sweepDual(input string tag);
    cfgSinglePort = 1'b0;
    for (int a = 0; a < 64; a++)
      readAt(tag, 8'((a * 11 + 3) & 8'hff), 6'(a));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        $display("FAIL watchdog: run hung, got %0d cycles expected under 100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset held with enable high must not write, and loads zero
    wrEn = 1'b1; dataIn = 2'b11; wrAddr = 8'h15;
    @(negedge clk);
    wrEn = 1'b0; rstN = 1'b1;
    cfgWide = 1'b0; sweepDual("R1 narrow after reset");
    cfgWide = 1'b1; sweepDual("R1 wide after reset");

    // R2 R3 R7 R9: narrow fill with decoys on dataIn[1] and wrAddr[7:6]
    cfgWide = 1'b0; cfgSinglePort = 1'b0;
    for (int a = 0; a < 64; a++) begin
      logic b;
      b = 1'(((a * 7) ^ (a >> 2)) & 1);
      writeAt({2'(a % 4), 6'(a)}, {~b, b}, 6'(63 - a));
    end
    sweepDual("R2 R3 R7 R9 narrow readback");

    // R11: same storage seen as 32x2, rdAddr[5] decoy (R5)
    cfgWide = 1'b1;
    for (int k = 0; k < 32; k++)
      readAt("R11 R5 narrow-written read wide", 8'h00, {1'(k & 1), 5'(k)});

    // R4 R9: wide fill, wrAddr[5] and [7:6] decoys
    for (int k = 0; k < 32; k++)
      writeAt({2'(3 - (k % 4)), 1'(k & 1), 5'(k)}, 2'((k * 3 + 1) & 3), 6'(k));
    sweepDual("R4 R5 wide readback");

    // R11: wide-written contents through the narrow view
    cfgWide = 1'b0;
    for (int a = 0; a < 64; a++)
      readAt("R11 wide-written read narrow", 8'h00, 6'(a));

    // R6: single-port, rdAddr driven opposite; both organisations
    cfgSinglePort = 1'b1;
    for (int a = 0; a < 64; a++)
      readAt("R6 single-port narrow", {2'(a % 4), 6'(a)}, ~6'(a));
    cfgWide = 1'b1;
    for (int a = 0; a < 64; a++)
      readAt("R6 single-port wide", 8'(a), ~6'(a));

    // R8: new data visible right after the writing edge
    for (int a = 0; a < 64; a += 5) begin
      logic eh, el;
      cfgWide = 1'(a & 1); cfgSinglePort = 1'b1;
      @(negedge clk);
      wrAddr = 8'(a); rdAddr = 6'(a + 9); dataIn = 2'((a + 2) & 3); wrEn = 1'b1;
      if (cfgWide) begin
        model[{1'b0, wrAddr[4:0]}] = dataIn[0];
        model[{1'b1, wrAddr[4:0]}] = dataIn[1];
      end else begin
        model[wrAddr[5:0]] = dataIn[0];
      end
      @(posedge clk); #1;
      expectFor(eh, el);
      check("R8 read after write same cycle", eh, el);
      @(negedge clk); wrEn = 1'b0;
    end

    // R10: enable low, busy data and addresses, contents unchanged
    cfgWide = 1'b0; cfgSinglePort = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      wrEn = 1'b0; wrAddr = 8'(i * 13); dataIn = 2'(i); rdAddr = 6'(i);
    end
    sweepDual("R10 no write when disabled");
    cfgWide = 1'b1;
    sweepDual("R10 no write when disabled wide");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule